// File: doc/BRIEF.md
# 4x4 Matrix Arithmetic Datapath

This block adds, subtracts or multiplies two 4x4 matrices of 16-bit two's complement elements. The operands sit in two 16-word operand memories and the result goes to a 16-word result memory. In all three memories, row r and column c are stored at address 4r+c. The operand memories are filled through a write port. The result memory is read through a combinational read port. A one-cycle `start_i` pulse launches the operation chosen by `op_i`, and `done_o` pulses once when the last result word has been written.

Multiplication runs in two passes. The product pass takes 64 cycles. In it, an operand-A element is held in a gating register for four cycles while it is multiplied by the four elements of one row of B. Each product is scattered into one of four bank memories, chosen by a one-hot decode of the bank index. The summation pass then reads all four banks at one address per cycle. It adds them through two first-level adders and one final adder, and writes the sum to the result memory. The write address is delayed to match the adder register.

Addition and subtraction skip the product pass. A bypass multiplexer routes the raw operand words to the final adder, which adds or subtracts element by element.

Top module: `mat_alu`

## Requirements
- R1: After reset, `done_o` is 0, every result word reads 0, and no result word is written until a run is started.
- R2: With `op_i` = 2'b00, a run writes C[n] = (A[n] + B[n]) mod 2^16 for every n in 0..15.
- R3: With `op_i` = 2'b01, a run writes C[n] = (A[n] - B[n]) mod 2^16 for every n in 0..15.
- R4: With `op_i` = 2'b10, a run writes C[4r+c] = sum over k of A[4r+k]*B[4k+c] for all r, c in 0..3. The product pass writes at most one bank memory per cycle.
- R5: Every product and every partial or final sum is truncated to its low 16 bits. Overflow wraps and is not flagged.
- R6: `done_o` is high for exactly one cycle, directly after the write of result address 15. Count rising edges from the edge that samples `start_i`, with that edge as 1. `done_o` is seen high after edge 18 for add or subtract, and after edge 82 for multiply.
- R7: A `start_i` pulse that comes while a run is in progress is ignored. The running operation, its result and its `done_o` timing are unchanged.
- R8: A `start_i` pulse with `op_i` = 2'b11 is ignored. No result word changes and `done_o` stays 0.
- R9: When `a_we_i` or `b_we_i` is high at a rising edge, `ld_data_i` is written to that operand memory at `ld_addr_i`. `rd_data_o` shows result word `rd_addr_i` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch pulse, sampled when idle |
| op_i | input | 2 | 00 add, 01 subtract, 10 multiply, 11 ignored |
| done_o | output | 1 | One-cycle completion pulse |
| a_we_i | input | 1 | Write enable, operand memory A |
| b_we_i | input | 1 | Write enable, operand memory B |
| ld_addr_i | input | 4 | Operand write address (4r+c) |
| ld_data_i | input | 16 | Operand write data |
| rd_addr_i | input | 4 | Result read address (4r+c) |
| rd_data_o | output | 16 | Result word at `rd_addr_i` |

## Verification
The assertions assume that the operand memories are not written while a run is in progress, since a run reads A and B across many cycles. They also assume that `start_i` is a single-cycle pulse. The stimulus loads both memories only while the block is idle, waits for `done_o` before the next load, and raises `start_i` for one cycle at a time. The single exception is the deliberate second pulse sent during a multiply run to show that it is ignored.

// File: rtl/mat_alu_pkg.sv
package mat_alu_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_MUL  = 2'b10,
    OP_NONE = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PROD,
    ST_SUM,
    ST_DRAIN
  } state_e;
endpackage

// File: rtl/mat_bank.sv
module mat_bank #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/mat_seq.sv
module mat_seq
  import mat_alu_pkg::*;
#(
  parameter int N   = 4,
  localparam int LN = $clog2(N),
  localparam int AW = 2 * LN,
  localparam int CW = 3 * LN
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    op_i,
  output logic [AW-1:0] a_raddr_o,
  output logic [AW-1:0] b_raddr_o,
  output logic          prod_v_o,
  output logic          a_ld_o,
  output logic [LN-1:0] bank_o,
  output logic [AW-1:0] t_waddr_o,
  output logic          sum_v_o,
  output logic [AW-1:0] sum_addr_o,
  output logic          bypass_o,
  output logic          sub_o,
  output logic          busy_o,
  output logic          done_o
);
  state_e        state_q;
  op_e           op_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= OP_ADD;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= (state_q == ST_DRAIN);
      unique case (state_q)
        ST_IDLE: begin
          if (start_i && op_e'(op_i) != OP_NONE) begin
            op_q    <= op_e'(op_i);
            cnt_q   <= '0;
            state_q <= (op_e'(op_i) == OP_MUL) ? ST_PROD : ST_SUM;
          end
        end
        ST_PROD: begin
          cnt_q <= cnt_q + 1'b1;
          if (&cnt_q) state_q <= ST_SUM;
        end
        ST_SUM: begin
          cnt_q <= cnt_q + 1'b1;
          if (&cnt_q[AW-1:0]) state_q <= ST_DRAIN;
        end
        ST_DRAIN: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  // product pass: A index advances every N cycles, B index every cycle
  assign prod_v_o   = (state_q == ST_PROD);
  assign a_ld_o     = prod_v_o && (cnt_q[LN-1:0] == '0);
  assign a_raddr_o  = prod_v_o ? cnt_q[CW-1:LN] : cnt_q[AW-1:0];
  assign b_raddr_o  = cnt_q[AW-1:0];
  assign bank_o     = cnt_q[AW-1:LN];
  assign t_waddr_o  = {cnt_q[CW-1:AW], cnt_q[LN-1:0]};
  assign sum_v_o    = (state_q == ST_SUM);
  assign sum_addr_o = cnt_q[AW-1:0];
  assign bypass_o   = (op_q != OP_MUL);
  assign sub_o      = (op_q == OP_SUB);
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
endmodule

// File: rtl/mat_dp.sv
module mat_dp #(
  parameter int N   = 4,
  parameter int DW  = 16,
  localparam int LN = $clog2(N),
  localparam int AW = 2 * LN,
  localparam int NB = N,
  localparam int NL = NB / 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [DW-1:0]          a_rd_i,
  input  logic [DW-1:0]          b_rd_i,
  input  logic                   prod_v_i,
  input  logic                   a_ld_i,
  input  logic [LN-1:0]          bank_i,
  input  logic [AW-1:0]          t_waddr_i,
  input  logic                   sum_v_i,
  input  logic [AW-1:0]          sum_addr_i,
  input  logic                   bypass_i,
  input  logic                   sub_i,
  input  logic [NB-1:0][DW-1:0]  tmp_rd_i,
  output logic [NB-1:0]          tmp_we_o,
  output logic [AW-1:0]          tmp_waddr_o,
  output logic [DW-1:0]          tmp_wdata_o,
  output logic                   c_we_o,
  output logic [AW-1:0]          c_waddr_o,
  output logic [DW-1:0]          c_wdata_o
);
  // operand gating registers and product-stage tags
  logic [DW-1:0] a_q, b_q;
  logic          pv_q;
  logic [LN-1:0] bank_q;
  logic [AW-1:0] tw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q    <= '0;
      b_q    <= '0;
      pv_q   <= 1'b0;
      bank_q <= '0;
      tw_q   <= '0;
    end else begin
      if (a_ld_i)   a_q <= a_rd_i;
      if (prod_v_i) b_q <= b_rd_i;
      pv_q   <= prod_v_i;
      bank_q <= bank_i;
      tw_q   <= t_waddr_i;
    end
  end

  logic [2*DW-1:0] prod_full;
  assign prod_full   = a_q * b_q;
  assign tmp_wdata_o = prod_full[DW-1:0];
  assign tmp_waddr_o = tw_q;

  for (genvar k = 0; k < NB; k++) begin : g_dec
    assign tmp_we_o[k] = pv_q && (bank_q == LN'(k));
  end

  // first adder level, with bypass of raw operands
  logic [NL-1:0][DW-1:0] l1_d, l1_q;
  for (genvar i = 0; i < NL; i++) begin : g_l1
    logic [DW-1:0] raw;
    if (i == 0)      begin : g_a assign raw = a_rd_i; end
    else if (i == 1) begin : g_b assign raw = b_rd_i; end
    else             begin : g_z assign raw = '0;     end
    assign l1_d[i] = bypass_i ? raw : (tmp_rd_i[2*i] + tmp_rd_i[2*i+1]);
  end

  logic          sv_q;
  logic [AW-1:0] sa_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l1_q <= '0;
      sv_q <= 1'b0;
      sa_q <= '0;
    end else begin
      l1_q <= l1_d;
      sv_q <= sum_v_i;
      sa_q <= sum_addr_i;
    end
  end

  // final adder
  logic [DW-1:0] rest;
  always_comb begin
    rest = '0;
    for (int i = 1; i < NL; i++) rest = rest + l1_q[i];
  end

  assign c_wdata_o = sub_i ? (l1_q[0] - rest) : (l1_q[0] + rest);
  assign c_we_o    = sv_q;
  assign c_waddr_o = sa_q;
endmodule

// File: rtl/mat_alu.sv
module mat_alu #(
  parameter int N   = 4,
  parameter int DW  = 16,
  localparam int LN = $clog2(N),
  localparam int AW = 2 * LN,
  localparam int DEPTH = N * N,
  localparam int NB = N
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    op_i,
  output logic          done_o,
  input  logic          a_we_i,
  input  logic          b_we_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [DW-1:0] ld_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  logic [AW-1:0]         a_raddr, b_raddr, t_waddr, sum_addr;
  logic                  prod_v, a_ld, sum_v, bypass, sub, busy;
  logic [LN-1:0]         bank;
  logic [DW-1:0]         a_rd, b_rd;
  logic [NB-1:0][DW-1:0] tmp_rd;
  logic [NB-1:0]         tmp_we;
  logic [AW-1:0]         tmp_waddr;
  logic [DW-1:0]         tmp_wdata;
  logic                  c_we;
  logic [AW-1:0]         c_waddr;
  logic [DW-1:0]         c_wdata;

  mat_seq #(.N(N)) u_seq (
    .clk_i, .rst_ni, .start_i, .op_i,
    .a_raddr_o(a_raddr), .b_raddr_o(b_raddr),
    .prod_v_o(prod_v), .a_ld_o(a_ld), .bank_o(bank), .t_waddr_o(t_waddr),
    .sum_v_o(sum_v), .sum_addr_o(sum_addr),
    .bypass_o(bypass), .sub_o(sub), .busy_o(busy), .done_o
  );

  mat_bank #(.DW(DW), .DEPTH(DEPTH)) u_mem_a (
    .clk_i, .rst_ni, .we_i(a_we_i), .waddr_i(ld_addr_i), .wdata_i(ld_data_i),
    .raddr_i(a_raddr), .rdata_o(a_rd)
  );

  mat_bank #(.DW(DW), .DEPTH(DEPTH)) u_mem_b (
    .clk_i, .rst_ni, .we_i(b_we_i), .waddr_i(ld_addr_i), .wdata_i(ld_data_i),
    .raddr_i(b_raddr), .rdata_o(b_rd)
  );

  for (genvar k = 0; k < NB; k++) begin : g_tmp
    mat_bank #(.DW(DW), .DEPTH(DEPTH)) u_mem_t (
      .clk_i, .rst_ni, .we_i(tmp_we[k]), .waddr_i(tmp_waddr), .wdata_i(tmp_wdata),
      .raddr_i(sum_addr), .rdata_o(tmp_rd[k])
    );
  end

  mat_bank #(.DW(DW), .DEPTH(DEPTH)) u_mem_c (
    .clk_i, .rst_ni, .we_i(c_we), .waddr_i(c_waddr), .wdata_i(c_wdata),
    .raddr_i(rd_addr_i), .rdata_o(rd_data_o)
  );

  mat_dp #(.N(N), .DW(DW)) u_dp (
    .clk_i, .rst_ni,
    .a_rd_i(a_rd), .b_rd_i(b_rd),
    .prod_v_i(prod_v), .a_ld_i(a_ld), .bank_i(bank), .t_waddr_i(t_waddr),
    .sum_v_i(sum_v), .sum_addr_i(sum_addr), .bypass_i(bypass), .sub_i(sub),
    .tmp_rd_i(tmp_rd), .tmp_we_o(tmp_we), .tmp_waddr_o(tmp_waddr),
    .tmp_wdata_o(tmp_wdata), .c_we_o(c_we), .c_waddr_o(c_waddr), .c_wdata_o(c_wdata)
  );
endmodule

// File: rtl/mat_alu_chk.sv
module mat_alu_chk #(
  parameter int NB = 4,
  parameter int AW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [1:0]    op_i,
  input logic          done_o,
  input logic          busy,
  input logic [NB-1:0] tmp_we,
  input logic          c_we,
  input logic [AW-1:0] c_waddr
);
  a_r1_no_idle_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !c_we);

  a_r4_bank_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tmp_we));

  a_r4_pass_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|tmp_we) |-> !c_we);

  a_r2_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_we && $past(c_we) |-> c_waddr == AW'($past(c_waddr) + 1'b1));

  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r6_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(c_we) && ($past(c_waddr) == {AW{1'b1}}));

  a_r8_bad_op_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy && op_i == 2'b11 |=> !busy);

  a_r7_run_persists: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && !done_o && $past(busy) && !c_we |=> busy);
endmodule

bind mat_alu mat_alu_chk #(.NB(NB), .AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
  .done_o(done_o), .busy(busy), .tmp_we(tmp_we), .c_we(c_we), .c_waddr(c_waddr)
);

// File: tb/mat_alu_tb_top.sv
module mat_alu_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic        done_o;
  logic        a_we_i = 1'b0, b_we_i = 1'b0;
  logic [3:0]  ld_addr_i = '0, rd_addr_i = '0;
  logic [15:0] ld_data_i = '0;
  logic [15:0] rd_data_o;

  int checks = 0;
  int errors = 0;
  logic [15:0] ma [16];
  logic [15:0] mb [16];
  logic [15:0] exp_c [16];

  always #4 clk_i = ~clk_i;

  mat_alu dut_i (
    .clk_i, .rst_ni, .start_i, .op_i, .done_o,
    .a_we_i, .b_we_i, .ld_addr_i, .ld_data_i, .rd_addr_i, .rd_data_o
  );

  // {op, seed}; seed 0 selects constant operands that overflow
  localparam logic [9:0] VEC [6] = '{
    {2'b00, 8'd0}, {2'b01, 8'd0}, {2'b10, 8'd0},
    {2'b00, 8'd5}, {2'b01, 8'd9}, {2'b10, 8'd7}
  };

  function automatic logic [15:0] gen(int s, int idx, bit isb);
    if (s == 0) return isb ? 16'h8003 : 16'h8001;
    return 16'(s * (idx * 2731 + 1) + (isb ? idx * 977 + 40000 : idx * 613));
  endfunction

  function automatic logic [15:0] expect_at(logic [1:0] op, int n);
    logic [15:0] acc;
    case (op)
      2'b00: return ma[n] + mb[n];
      2'b01: return ma[n] - mb[n];
      default: begin
        acc = '0;
        for (int k = 0; k < 4; k++)
          acc = acc + 16'(ma[4*(n/4)+k] * mb[4*k+(n%4)]);
        return acc;
      end
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load(int s);
    for (int i = 0; i < 16; i++) begin
      ma[i] = gen(s, i, 1'b0);
      mb[i] = gen(s, i, 1'b1);
    end
    for (int i = 0; i < 16; i++) begin
      @(negedge clk_i);
      a_we_i = 1'b1; ld_addr_i = 4'(i); ld_data_i = ma[i];
    end
    for (int i = 0; i < 16; i++) begin
      @(negedge clk_i);
      a_we_i = 1'b0; b_we_i = 1'b1; ld_addr_i = 4'(i); ld_data_i = mb[i];
    end
    @(negedge clk_i);
    b_we_i = 1'b0;
  endtask

  // start sampled at edge 1; returns edge count at which done is seen
  task automatic run(logic [1:0] op, int inject, output int lat);
    lat = 0;
    @(negedge clk_i);
    op_i = op; start_i = 1'b1;
    for (int n = 1; n <= 150; n++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      start_i = 1'b0;
      if (inject != 0 && n == inject) begin
        op_i = 2'b00; start_i = 1'b1;
      end
      if (done_o) begin
        lat = n;
        break;
      end
    end
    start_i = 1'b0;
  endtask

  task automatic check_c(string req);
    for (int i = 0; i < 16; i++) begin
      rd_addr_i = 4'(i);
      #1;
      check(req, rd_data_o, exp_c[i]);
    end
  endtask

  task automatic full_case(logic [1:0] op, int s, int inject);
    int lat;
    string req;
    req = (op == 2'b00) ? "R2" : (op == 2'b01) ? "R3" : "R4";
    load(s);
    for (int i = 0; i < 16; i++) exp_c[i] = expect_at(op, i);
    run(op, inject, lat);
    check("R6 latency", lat, (op == 2'b10) ? 82 : 18);
    @(negedge clk_i);
    check("R6 width", done_o, 1'b0);
    check_c(s == 0 ? {req, " R5"} : req);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seen;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1: reset state
    check("R1 done", done_o, 1'b0);
    for (int i = 0; i < 16; i++) exp_c[i] = '0;
    check_c("R1 R9");

    // R9: loads alone change nothing at the result port
    load(3);
    repeat (5) @(negedge clk_i);
    check("R1 idle", done_o, 1'b0);
    check_c("R1 R9");

    for (int v = 0; v < 6; v++)
      full_case(VEC[v][9:8], int'(VEC[v][7:0]), 0);

    // R7: second start during multiply
    full_case(2'b10, 11, 30);

    // R8: reserved opcode
    @(negedge clk_i);
    op_i = 2'b11; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    seen = 0;
    for (int n = 0; n < 100; n++) begin
      @(negedge clk_i);
      if (done_o) seen++;
    end
    check("R8 done", seen, 0);
    check_c("R8");

    // R7: a stale result from a prior run is fully overwritten by a new one
    full_case(2'b01, 13, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule